// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block is the output stage of one compare channel of an 8-bit timer. The counter lives elsewhere and supplies one-cycle strobes: a compare match, the counter reaching BOTTOM, and the counter reaching TOP. It also supplies the count direction and a flag that is high when this channel's compare value equals TOP. From these strobes the block keeps a single waveform bit. It sets, clears or toggles that bit according to a 2-bit output-mode field, the waveform class of the timer (non-PWM, fast PWM or phase-correct PWM) and whether the instance serves channel A or channel B.

When the mode field connects the channel, the block overrides the pin. The pin is driven with the waveform bit only when the external direction-enable bit is also high. In every other case the ordinary port data passes through to the pin. The mode field is registered, so a change made to it first acts one clock later. The counter and the prescaler sit outside this block.

Top module: `cmp_wave_out`

## Requirements
- R1: A registered mode value of 00 disconnects the channel. `override` is low, and no strobe changes the waveform bit.
- R2: Class code 00 (non-PWM) and class code 11 (also handled as non-PWM) act on a compare match as follows. Mode 01 toggles the waveform bit, mode 10 clears it and mode 11 sets it. The other strobes have no effect.
- R3: Class code 01 (fast PWM) works as follows. Mode 10 clears the bit on a match and sets it at BOTTOM. Mode 11 sets the bit on a match and clears it at BOTTOM.
- R4: Class code 10 (phase-correct PWM) works as follows. Mode 10 clears the bit on a match while counting up (`count_down`=0) and sets it on a match while counting down. Mode 11 does the reverse. The BOTTOM strobe and the TOP strobe have no effect unless R6 applies.
- R5: In either PWM class, mode 01 toggles the bit on a match only when `is_chan_a` and `top_from_a` are both high. In every other case mode 01 is disconnected: `override` is low and the bit holds.
- R6: In either PWM class with mode bit 1 set and `cmp_is_top` high, matches are ignored. The bit takes the inverse of mode bit 0 at BOTTOM in fast PWM, or at TOP in phase-correct PWM.
- R7: In fast PWM, a match that arrives in the same cycle as BOTTOM takes priority over the BOTTOM action.
- R8: `pin_drive` is high exactly when `override` and `dir_en` are both high. `pin_out` then equals `wave`; otherwise `pin_out` equals `port_data`.
- R9: While `rst_n` is low, `wave` is 0 and the registered mode is 00.
- R10: A new `mode_sel` value takes effect at the clock edge that captures it. A strobe in the same cycle as the write still uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Compare output mode field |
| wave_class | input | 2 | 00 non-PWM, 01 fast PWM, 10 phase-correct PWM, 11 non-PWM |
| match | input | 1 | Compare match strobe |
| at_bottom | input | 1 | Counter at BOTTOM strobe |
| at_top | input | 1 | Counter at TOP strobe |
| count_down | input | 1 | Counter is counting down |
| cmp_is_top | input | 1 | Channel compare value equals TOP |
| is_chan_a | input | 1 | Instance serves channel A |
| top_from_a | input | 1 | Active mode takes TOP from the channel-A compare value |
| dir_en | input | 1 | External direction-enable bit for the pin |
| port_data | input | 1 | Ordinary port data for the pin |
| wave | output | 1 | Waveform bit |
| override | output | 1 | Channel connected, waveform overrides the port function |
| pin_drive | output | 1 | Pin driven by the waveform |
| pin_out | output | 1 | Value presented to the pin |

## Verification
A wrong waveform bit shows on `wave` and on `pin_out` in the cycle right after the strobe that set it wrong. It then stays wrong until a later action happens to correct it. The table therefore chains vectors so that each one starts from the bit the previous vector left, and a stale or inverted bit is caught at the next check. A wrong registered mode shows at once on `override`. It also shows as a wrong action on the first strobe after the write, and the latency test observes that edge directly.

// File: rtl/cmp_wave_out.sv
module cmp_wave_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic [1:0] wave_class,
  input  logic       match,
  input  logic       at_bottom,
  input  logic       at_top,
  input  logic       count_down,
  input  logic       cmp_is_top,
  input  logic       is_chan_a,
  input  logic       top_from_a,
  input  logic       dir_en,
  input  logic       port_data,
  output logic       wave,
  output logic       override,
  output logic       pin_drive,
  output logic       pin_out
);
  localparam logic [1:0] CLS_FAST  = 2'b01;
  localparam logic [1:0] CLS_PHASE = 2'b10;

  logic [1:0] mode_q;
  logic       wave_nxt;
  logic       pwm, toggle_mode;

  assign pwm         = (wave_class == CLS_FAST) || (wave_class == CLS_PHASE);
  assign toggle_mode = (mode_q == 2'b01);
  assign override    = (mode_q != 2'b00) &&
                       !(pwm && toggle_mode && !(is_chan_a && top_from_a));
  assign pin_drive   = override && dir_en;
  assign pin_out     = pin_drive ? wave : port_data;

  always_comb begin
    wave_nxt = wave;
    if (override) begin
      if (!pwm || toggle_mode) begin
        if (match) wave_nxt = toggle_mode ? ~wave : mode_q[0];
      end else if (wave_class == CLS_FAST) begin
        if (at_bottom) wave_nxt = ~mode_q[0];
        if (match && !cmp_is_top) wave_nxt = mode_q[0];
      end else begin
        if (match && !cmp_is_top) wave_nxt = mode_q[0] ^ count_down;
        if (at_top && cmp_is_top) wave_nxt = ~mode_q[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      wave   <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      wave   <= wave_nxt;
    end
  end
endmodule

// File: rtl/cmp_wave_out_chk.sv
module cmp_wave_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic [1:0] wave_class,
  input logic       match,
  input logic       at_bottom,
  input logic       cmp_is_top,
  input logic       port_data,
  input logic       wave,
  input logic       override,
  input logic       pin_drive,
  input logic       pin_out
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !override |=> $stable(wave));

  assert_np_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b00 && mode_q == 2'b11 && match) |=> wave);

  assert_fast_bottom_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b01 && mode_q == 2'b10 && at_bottom && !match) |=> wave);

  assert_top_match_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b01 && mode_q[1] && cmp_is_top && match && !at_bottom) |=> $stable(wave));

  assert_pin_wave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive |-> (pin_out == wave && override));

  assert_pin_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !override |-> (pin_out == port_data && !pin_drive));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!wave && mode_q == 2'b00));
endmodule

bind cmp_wave_out cmp_wave_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .wave_class(wave_class),
  .match(match), .at_bottom(at_bottom), .cmp_is_top(cmp_is_top),
  .port_data(port_data), .wave(wave), .override(override),
  .pin_drive(pin_drive), .pin_out(pin_out)
);

// File: tb/cmp_wave_out_tb.sv
module cmp_wave_out_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00, wave_class = 2'b00;
  logic match = 0, at_bottom = 0, at_top = 0, count_down = 0, cmp_is_top = 0;
  logic is_chan_a = 0, top_from_a = 0, dir_en = 0, port_data = 0;
  logic wave, override, pin_drive, pin_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_wave_out u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wave_class(wave_class),
    .match(match), .at_bottom(at_bottom), .at_top(at_top), .count_down(count_down),
    .cmp_is_top(cmp_is_top), .is_chan_a(is_chan_a), .top_from_a(top_from_a),
    .dir_en(dir_en), .port_data(port_data), .wave(wave), .override(override),
    .pin_drive(pin_drive), .pin_out(pin_out)
  );

  // fields: req[3:0] mode[1:0] cls[1:0] match bottom top down cmp_top chan_a top_a exp_wave exp_ovr
  localparam int NV = 27;
  localparam logic [16:0] VEC [NV] = '{
    17'b0010_11_00_1_0_0_0_0_0_0_1_1, // R2 set
    17'b0010_10_00_1_0_0_0_0_0_0_0_1, // R2 clear
    17'b0010_01_00_1_0_0_0_0_0_0_1_1, // R2 toggle
    17'b0001_00_00_1_0_0_0_0_0_0_1_0, // R1 disconnected, held
    17'b0010_01_00_1_0_0_0_0_0_0_0_1, // R2 toggle back
    17'b0011_10_01_0_1_0_0_0_0_0_1_1, // R3 set at bottom
    17'b0011_10_01_1_0_0_0_0_0_0_0_1, // R3 clear on match
    17'b0011_11_01_0_1_0_0_0_0_0_0_1, // R3 inverting clear at bottom
    17'b0011_11_01_1_0_0_0_0_0_0_1_1, // R3 inverting set on match
    17'b0110_10_01_1_0_0_0_1_0_0_1_1, // R6 match ignored
    17'b0110_11_01_0_1_0_0_1_0_0_0_1, // R6 boundary action at bottom
    17'b0101_01_01_1_0_0_0_0_0_0_0_0, // R5 channel B reserved
    17'b0101_01_01_1_0_0_0_0_1_0_0_0, // R5 channel A, top not from A
    17'b0101_01_01_1_0_0_0_0_1_1_1_1, // R5 channel A toggles
    17'b0100_10_10_1_0_0_0_0_0_0_0_1, // R4 up clear
    17'b0100_10_10_1_0_0_1_0_0_0_1_1, // R4 down set
    17'b0100_11_10_1_0_0_1_0_0_0_0_1, // R4 inverted down clear
    17'b0100_11_10_1_0_0_0_0_0_0_1_1, // R4 inverted up set
    17'b0110_10_10_1_0_0_0_1_0_0_1_1, // R6 phase match ignored
    17'b0110_11_10_0_0_1_0_1_0_0_0_1, // R6 clear at top
    17'b0110_10_10_0_0_1_0_1_0_0_1_1, // R6 set at top
    17'b0100_10_10_0_0_1_0_0_0_0_1_1, // R4 top alone no effect
    17'b0101_01_10_1_0_0_0_0_0_0_1_0, // R5 phase channel B reserved
    17'b0101_01_10_1_0_0_0_0_1_1_0_1, // R5 phase channel A toggles
    17'b0111_11_01_1_1_0_0_0_0_0_1_1, // R7 match beats bottom
    17'b0010_10_11_1_0_0_0_0_0_0_0_1, // R2 class 11 as non-PWM
    17'b0100_10_10_0_1_0_0_0_0_0_0_1  // R4 bottom no effect
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic clear_strobes();
    match = 0; at_bottom = 0; at_top = 0; count_down = 0; cmp_is_top = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    port_data = 1;
    repeat (2) @(negedge clk);
    check("R9", "wave in reset", wave, 1'b0);
    check("R9", "override in reset", override, 1'b0);
    check("R8", "pin passes port in reset", pin_out, 1'b1);
    rst_n = 1;
    @(negedge clk);

    // R10: mode write and match in the same cycle use the old mode
    mode_sel = 2'b11; match = 1;
    #1 check("R10", "override before edge", override, 1'b0);
    @(negedge clk);
    check("R10", "match used old mode", wave, 1'b0);
    check("R10", "override after edge", override, 1'b1);
    @(negedge clk);
    check("R10", "match uses new mode", wave, 1'b1);
    match = 0;
    mode_sel = 2'b10; match = 1;
    @(negedge clk);
    match = 0;
    @(negedge clk);

    dir_en = 1;
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d", v[16:13]);
      mode_sel = v[12:11]; wave_class = v[10:9];
      is_chan_a = v[3]; top_from_a = v[2];
      clear_strobes();
      @(negedge clk);
      match = v[8]; at_bottom = v[7]; at_top = v[6]; count_down = v[5]; cmp_is_top = v[4];
      port_data = i[0];
      @(negedge clk);
      clear_strobes();
      check(tg, $sformatf("vector %0d wave", i), wave, v[1]);
      check(tg, $sformatf("vector %0d override", i), override, v[0]);
      check("R8", $sformatf("vector %0d pin", i), pin_out, v[0] ? v[1] : port_data);
    end

    // R8: override active but direction bit low
    dir_en = 0; port_data = ~wave;
    #1 check("R8", "pin_drive with dir_en low", pin_drive, 1'b0);
    check("R8", "pin passes port", pin_out, port_data);
    dir_en = 1;
    #1 check("R8", "pin_drive with dir_en high", pin_drive, 1'b1);

    // R9: reset mid-run clears a set waveform
    wave_class = 2'b00; mode_sel = 2'b11;
    @(negedge clk);
    match = 1;
    @(negedge clk);
    match = 0;
    check("R2", "set before reset", wave, 1'b1);
    rst_n = 0;
    #1 check("R9", "wave cleared by reset", wave, 1'b0);
    check("R9", "override cleared by reset", override, 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    summary();
  end
endmodule